// File: doc/BRIEF.md
# Descriptor-Driven Channel Sequencer

This block is one channel of a descriptor-based offload engine. The host hands the channel a job by writing a single descriptor pointer into a small pointer queue. The channel then runs the whole job without further host help. It reads the eight-word descriptor from memory and decodes the header. It obtains execution units from a shared controller. It streams key, context and data words to those units in that order, writes the unit results to the result buffer, and reports completion.

Every memory access is one 64-bit word over a request/grant port. The execution units, the bus arbiter and the multi-channel controller sit outside the block. They are represented only by their handshakes. Completion is reported by a done interrupt, by writing the header and a status word back to memory, or by both, as the header selects. An unsupported operation code ends the job early with an error interrupt.

The descriptor is eight 64-bit words at the pointer, held as byte addresses with a word stride of 8. Word 0 is the header. Words 1 and 2 hold the key pointer and key length. Words 3 and 4 hold the context pointer and length. Words 5 and 6 hold the data pointer and length. Word 7 is the result pointer. Lengths count 64-bit words and sit in bits [15:0].

Top module: `desc_channel_seq`

## Requirements
- R1: With the pointer queue empty, the channel makes no memory request. A job starts only after a pointer is written through `host_wr_en`/`host_wr_ptr`.
- R2: A job begins with eight read requests at the pointer and the seven following word addresses (pointer + 8·k, k = 0..7), granted in that order.
- R3: Header fields are: operation code in bits [63:56], unit mask in bits [55:52], notify bits in [1:0]. While `eu_req` is high, `eu_mask` equals the header mask.
- R4: No operand read is issued while the unit request is pending. `mem_req` stays low from the raise of `eu_req` until `eu_gnt`.
- R5: Operands are fetched in the order key, context, data. Each operand is read as length words from its pointer and presented on `eu_in_data` with `eu_in_sel` set to 0, 1 or 2. A zero-length operand is skipped.
- R6: After the operands, as many result words as the data length are taken from `eu_res_data` (one `eu_res_pop` per written word). They are written to consecutive words from the result pointer.
- R7: Notify bit 0 gives exactly one `irq_done` pulse at the end of the job. Notify bit 1 writes the header back to the pointer address, then writes a status word to pointer + 64. The status word has bit 63 set, the operation code in bits [7:0] and zeros elsewhere. With a bit clear, its action does not occur.
- R8: Operation codes 1 to NUM_OPS (default 4) are valid. Any other code, once units are granted, gives one `irq_err` pulse and no `irq_done`. It also causes no operand reads and no memory writes, and the channel accepts the next job.
- R9: The pointer queue holds 4 entries. A write while it is full is dropped and sets `fifo_ovf`, which stays set until reset.
- R10: Every job, completed or aborted, ends with exactly one `eu_release` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr_en | input | 1 | Host writes a descriptor pointer |
| host_wr_ptr | input | ADDR_W | Descriptor pointer (byte address) |
| fifo_ovf | output | 1 | Sticky pointer-queue overflow |
| mem_req | output | 1 | Memory request, held until granted |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | ADDR_W | Word byte address |
| mem_wdata | output | 64 | Write data |
| mem_gnt | input | 1 | Request accepted this cycle |
| mem_rdata | input | 64 | Read data, valid with the grant |
| eu_req | output | 1 | Unit assignment request |
| eu_mask | output | 4 | Units requested |
| eu_gnt | input | 1 | Units assigned |
| eu_release | output | 1 | Units released (pulse) |
| eu_in_valid | output | 1 | Operand word valid (pulse) |
| eu_in_sel | output | 2 | Operand kind: 0 key, 1 context, 2 data |
| eu_in_data | output | 64 | Operand word |
| eu_res_data | input | 64 | Next result word from the units |
| eu_res_pop | output | 1 | Result word consumed |
| irq_done | output | 1 | Job done interrupt (pulse) |
| irq_err | output | 1 | Job aborted interrupt (pulse) |

## Verification
The hardest case to reach from the ports is a channel that holds a decoded header while its unit request waits. No operand read may leak out while the channel waits. The bench withholds `eu_gnt` for dozens of cycles after the last descriptor read and counts read grants and overlaps of `eu_req` with `mem_req` during that window. The bench also provokes overflow with one pointer write on each of six consecutive cycles. The queue fills because the channel pops only one pointer per job. Exactly five jobs must then complete.

// File: rtl/chan_pkg.sv
package chan_pkg;
  localparam int WORD_W     = 64;
  localparam int DESC_WORDS = 8;

  typedef enum logic [3:0] {
    ST_IDLE, ST_DESC, ST_EUREQ, ST_SEG, ST_FETCH,
    ST_WBSET, ST_WBRES, ST_NOTE, ST_WBHDR, ST_WBSTAT, ST_FIN, ST_ABORT
  } seq_state_e;

  function automatic logic op_supported(input logic [7:0] op, input int num_ops);
    return (op != 8'd0) && (int'(op) <= num_ops);
  endfunction
endpackage

// File: rtl/chan_ptr_fifo.sv
module chan_ptr_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         rd_en,
  output logic [W-1:0] rd_data,
  output logic         empty,
  output logic         ovf
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  store [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [AW:0]   cnt_q;
  logic          full, do_wr, do_rd;

  assign full  = (cnt_q == (AW+1)'(DEPTH));
  assign empty = (cnt_q == '0);
  assign do_wr = wr_en && !full;
  assign do_rd = rd_en && !empty;
  assign rd_data = store[rp_q];

  always_ff @(posedge clk) begin
    if (do_wr) store[wp_q] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
      ovf   <= 1'b0;
    end else begin
      if (do_wr) wp_q <= (wp_q == AW'(DEPTH-1)) ? '0 : wp_q + 1'b1;
      if (do_rd) rp_q <= (rp_q == AW'(DEPTH-1)) ? '0 : rp_q + 1'b1;
      cnt_q <= cnt_q + (AW+1)'(do_wr) - (AW+1)'(do_rd);
      if (wr_en && full) ovf <= 1'b1;
    end
  end

  // R9
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst) ovf |=> ovf);
  // R9
  depth_bound_chk: assert property (@(posedge clk) disable iff (rst) cnt_q <= (AW+1)'(DEPTH));
endmodule

// File: rtl/chan_seq_core.sv
module chan_seq_core
  import chan_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int LEN_W   = 16,
  parameter int NUM_OPS = 4,
  parameter int EU_W    = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ptr_valid,
  input  logic [ADDR_W-1:0] ptr_data,
  output logic              ptr_pop,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic              mem_gnt,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              eu_req,
  output logic [EU_W-1:0]   eu_mask,
  input  logic              eu_gnt,
  output logic              eu_release,
  output logic              eu_in_valid,
  output logic [1:0]        eu_in_sel,
  output logic [WORD_W-1:0] eu_in_data,
  input  logic [WORD_W-1:0] eu_res_data,
  output logic              eu_res_pop,
  output logic              irq_done,
  output logic              irq_err
);
  localparam int IDX_W    = $clog2(DESC_WORDS);
  localparam int WORD_B   = WORD_W / 8;
  localparam int STAT_OFS = DESC_WORDS * WORD_B;

  seq_state_e        state_q;
  logic [IDX_W-1:0]  idx_q;
  logic [1:0]        seg_q;
  logic [LEN_W-1:0]  cnt_q;
  logic [ADDR_W-1:0] base_q;
  logic [WORD_W-1:0] hdr_q;
  logic [ADDR_W-1:0] ptr_q [4];
  logic [LEN_W-1:0]  len_q [3];
  logic              grant_rd;

  assign ptr_pop    = (state_q == ST_IDLE) && ptr_valid;
  assign grant_rd   = mem_req && mem_gnt && !mem_we;
  assign eu_res_pop = (state_q == ST_WBRES) && mem_gnt;

  always_comb begin
    unique case (state_q)
      ST_WBRES:  mem_wdata = eu_res_data;
      ST_WBHDR:  mem_wdata = hdr_q;
      ST_WBSTAT: mem_wdata = {1'b1, 55'd0, hdr_q[63:56]};
      default:   mem_wdata = '0;
    endcase
  end

  // descriptor field capture (no reset needed on storage)
  always_ff @(posedge clk) begin
    if (state_q == ST_DESC && mem_gnt) begin
      if (idx_q == '0)     hdr_q <= mem_rdata;
      else if (idx_q[0])   ptr_q[idx_q[2:1]] <= mem_rdata[ADDR_W-1:0];
      else                 len_q[idx_q[2:1] - 2'd1] <= mem_rdata[LEN_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      idx_q       <= '0;
      seg_q       <= '0;
      cnt_q       <= '0;
      base_q      <= '0;
      mem_req     <= 1'b0;
      mem_we      <= 1'b0;
      mem_addr    <= '0;
      eu_req      <= 1'b0;
      eu_mask     <= '0;
      eu_release  <= 1'b0;
      eu_in_valid <= 1'b0;
      eu_in_sel   <= '0;
      eu_in_data  <= '0;
      irq_done    <= 1'b0;
      irq_err     <= 1'b0;
    end else begin
      eu_release  <= 1'b0;
      eu_in_valid <= 1'b0;
      irq_done    <= 1'b0;
      irq_err     <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (ptr_valid) begin
          base_q   <= ptr_data;
          idx_q    <= '0;
          mem_req  <= 1'b1;
          mem_we   <= 1'b0;
          mem_addr <= ptr_data;
          state_q  <= ST_DESC;
        end
        ST_DESC: if (mem_gnt) begin
          if (idx_q == IDX_W'(DESC_WORDS-1)) begin
            mem_req <= 1'b0;
            eu_req  <= 1'b1;
            eu_mask <= hdr_q[55 -: EU_W];
            state_q <= ST_EUREQ;
          end else begin
            idx_q    <= idx_q + 1'b1;
            mem_addr <= mem_addr + ADDR_W'(WORD_B);
          end
        end
        ST_EUREQ: if (eu_gnt) begin
          eu_req  <= 1'b0;
          seg_q   <= '0;
          state_q <= op_supported(hdr_q[63:56], NUM_OPS) ? ST_SEG : ST_ABORT;
        end
        ST_SEG: begin
          if (len_q[seg_q] == '0) begin
            if (seg_q == 2'd2) state_q <= ST_WBSET;
            else               seg_q   <= seg_q + 1'b1;
          end else begin
            mem_req  <= 1'b1;
            mem_we   <= 1'b0;
            mem_addr <= ptr_q[seg_q];
            cnt_q    <= len_q[seg_q];
            state_q  <= ST_FETCH;
          end
        end
        ST_FETCH: if (mem_gnt) begin
          eu_in_valid <= 1'b1;
          eu_in_sel   <= seg_q;
          eu_in_data  <= mem_rdata;
          if (cnt_q == LEN_W'(1)) begin
            mem_req <= 1'b0;
            if (seg_q == 2'd2) state_q <= ST_WBSET;
            else begin
              seg_q   <= seg_q + 1'b1;
              state_q <= ST_SEG;
            end
          end else begin
            cnt_q    <= cnt_q - 1'b1;
            mem_addr <= mem_addr + ADDR_W'(WORD_B);
          end
        end
        ST_WBSET: begin
          if (len_q[2] == '0) state_q <= ST_NOTE;
          else begin
            mem_req  <= 1'b1;
            mem_we   <= 1'b1;
            mem_addr <= ptr_q[3];
            cnt_q    <= len_q[2];
            state_q  <= ST_WBRES;
          end
        end
        ST_WBRES: if (mem_gnt) begin
          if (cnt_q == LEN_W'(1)) begin
            mem_req <= 1'b0;
            mem_we  <= 1'b0;
            state_q <= ST_NOTE;
          end else begin
            cnt_q    <= cnt_q - 1'b1;
            mem_addr <= mem_addr + ADDR_W'(WORD_B);
          end
        end
        ST_NOTE: begin
          if (hdr_q[1]) begin
            mem_req  <= 1'b1;
            mem_we   <= 1'b1;
            mem_addr <= base_q;
            state_q  <= ST_WBHDR;
          end else state_q <= ST_FIN;
        end
        ST_WBHDR: if (mem_gnt) begin
          mem_addr <= base_q + ADDR_W'(STAT_OFS);
          state_q  <= ST_WBSTAT;
        end
        ST_WBSTAT: if (mem_gnt) begin
          mem_req <= 1'b0;
          mem_we  <= 1'b0;
          state_q <= ST_FIN;
        end
        ST_FIN: begin
          irq_done   <= hdr_q[0];
          eu_release <= 1'b1;
          state_q    <= ST_IDLE;
        end
        ST_ABORT: begin
          irq_err    <= 1'b1;
          eu_release <= 1'b1;
          state_q    <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R4
  no_fetch_before_grant_chk: assert property (@(posedge clk) disable iff (rst) eu_req |-> !mem_req);
  // R2
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));
  // R10
  done_releases_chk: assert property (@(posedge clk) disable iff (rst) (irq_done || irq_err) |-> eu_release);
  // R8
  single_irq_chk: assert property (@(posedge clk) disable iff (rst) $onehot0({irq_done, irq_err}));
  // R1
  idle_start_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE && !ptr_valid) |=> !mem_req);
  // R5
  operand_read_chk: assert property (@(posedge clk) disable iff (rst) eu_in_valid |-> $past(grant_rd));
endmodule

// File: rtl/desc_channel_seq.sv
module desc_channel_seq #(
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 16,
  parameter int NUM_OPS    = 4,
  parameter int EU_W       = 4,
  parameter int FIFO_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_wr_en,
  input  logic [ADDR_W-1:0] host_wr_ptr,
  output logic              fifo_ovf,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [63:0]       mem_wdata,
  input  logic              mem_gnt,
  input  logic [63:0]       mem_rdata,
  output logic              eu_req,
  output logic [EU_W-1:0]   eu_mask,
  input  logic              eu_gnt,
  output logic              eu_release,
  output logic              eu_in_valid,
  output logic [1:0]        eu_in_sel,
  output logic [63:0]       eu_in_data,
  input  logic [63:0]       eu_res_data,
  output logic              eu_res_pop,
  output logic              irq_done,
  output logic              irq_err
);
  logic              q_empty, q_pop;
  logic [ADDR_W-1:0] q_data;

  chan_ptr_fifo #(.W(ADDR_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .wr_en(host_wr_en), .wr_data(host_wr_ptr),
    .rd_en(q_pop), .rd_data(q_data), .empty(q_empty), .ovf(fifo_ovf)
  );

  chan_seq_core #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .NUM_OPS(NUM_OPS), .EU_W(EU_W)) u_core (
    .clk(clk), .rst(rst),
    .ptr_valid(!q_empty), .ptr_data(q_data), .ptr_pop(q_pop),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_gnt(mem_gnt), .mem_rdata(mem_rdata),
    .eu_req(eu_req), .eu_mask(eu_mask), .eu_gnt(eu_gnt), .eu_release(eu_release),
    .eu_in_valid(eu_in_valid), .eu_in_sel(eu_in_sel), .eu_in_data(eu_in_data),
    .eu_res_data(eu_res_data), .eu_res_pop(eu_res_pop),
    .irq_done(irq_done), .irq_err(irq_err)
  );
endmodule

// File: tb/sim_desc_channel_seq.sv
module sim_desc_channel_seq;
  localparam int MW = 512;
  logic clk = 1'b0, rst = 1'b1;
  always #2 clk = ~clk;

  logic        host_wr_en = 1'b0;
  logic [31:0] host_wr_ptr = '0;
  logic        fifo_ovf, mem_req, mem_we, mem_gnt, eu_req, eu_gnt, eu_release;
  logic        eu_in_valid, eu_res_pop, irq_done, irq_err;
  logic [31:0] mem_addr;
  logic [63:0] mem_wdata, mem_rdata, eu_in_data, eu_res_data;
  logic [3:0]  eu_mask;
  logic [1:0]  eu_in_sel;

  logic [63:0] mem [MW];
  logic        stall_en = 1'b0, stall = 1'b0, eu_allow = 1'b1;
  logic        pk_en = 1'b0;
  int          pk_i = 0;
  logic [63:0] pk_v = '0;
  int rd_n = 0, wr_n = 0, fed_n = 0, done_n = 0, err_n = 0, rel_n = 0, overlap_n = 0, req_n = 0;
  logic [31:0] res_cnt = '0;
  logic [31:0] rd_log [64];
  logic [63:0] fed_data [256];
  logic [1:0]  fed_sel [256];
  logic [3:0]  mask_seen = '0;
  int checks = 0, errors = 0;
  bit finished = 0;

  assign mem_gnt     = mem_req && !stall;
  assign mem_rdata   = mem[mem_addr[11:3]];
  assign eu_gnt      = eu_req && eu_allow;
  assign eu_res_data = {32'hCAFE0000, res_cnt};

  desc_channel_seq u0 (.*);

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < MW; i++) mem[i] <= {32'hD0D00000, 32'(i)};
    end else begin
      if (pk_en) mem[pk_i] <= pk_v;
      if (mem_req && mem_gnt && mem_we) begin mem[mem_addr[11:3]] <= mem_wdata; wr_n <= wr_n + 1; end
      if (mem_req && mem_gnt && !mem_we) begin rd_log[rd_n % 64] <= mem_addr; rd_n <= rd_n + 1; end
      if (mem_req) req_n <= req_n + 1;
      if (eu_in_valid) begin fed_data[fed_n % 256] <= eu_in_data; fed_sel[fed_n % 256] <= eu_in_sel; fed_n <= fed_n + 1; end
      if (irq_done) done_n <= done_n + 1;
      if (irq_err) err_n <= err_n + 1;
      if (eu_release) rel_n <= rel_n + 1;
      if (eu_req && mem_req) overlap_n <= overlap_n + 1;
      if (eu_req) mask_seen <= eu_mask;
      if (eu_res_pop) res_cnt <= res_cnt + 1;
      stall <= stall_en && !stall;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic poke(input int i, input logic [63:0] v);
    @(negedge clk); pk_en = 1'b1; pk_i = i; pk_v = v;
    @(negedge clk); pk_en = 1'b0;
  endtask

  function automatic logic [63:0] pat(input int i);
    return {32'hD0D00000, 32'(i)};
  endfunction

  // descriptor at word index b; operands at 64/96/128, result at 192
  task automatic set_desc(input int b, input logic [7:0] op, input logic [3:0] msk, input logic [1:0] ntf,
                          input int kl, input int cl, input int dl);
    poke(b,   {op, msk, 50'd0, ntf});
    poke(b+1, 64'(64*8));  poke(b+2, 64'(kl));
    poke(b+3, 64'(96*8));  poke(b+4, 64'(cl));
    poke(b+5, 64'(128*8)); poke(b+6, 64'(dl));
    poke(b+7, 64'(192*8));
    poke(b+8, 64'h0);
    for (int j = 0; j < 4; j++) poke(192+j, 64'h5555);
  endtask

  task automatic push(input int b);
    @(negedge clk); host_wr_en = 1'b1; host_wr_ptr = 32'(b*8);
    @(negedge clk); host_wr_en = 1'b0;
  endtask

  task automatic wait_rel(input int target);
    for (int k = 0; k < 3000 && rel_n < target; k++) @(negedge clk);
  endtask

  task automatic t_reset;
    chk(!mem_req && !mem_we, "R1 reset mem_req", 64'(mem_req), 0);
    chk(!eu_req && !eu_release, "R10 reset eu", 64'(eu_req), 0);
    chk(!irq_done && !irq_err, "R7 reset irq", 64'({irq_done, irq_err}), 0);
    chk(!fifo_ovf, "R9 reset ovf", 64'(fifo_ovf), 0);
  endtask

  task automatic t_idle_quiet;
    int r0 = req_n;
    repeat (20) @(negedge clk);
    chk(req_n == r0, "R1 no request while queue empty", 64'(req_n - r0), 0);
  endtask

  task automatic t_basic;
    int rd0, fd0, d0, rl0; logic [31:0] rs0;
    set_desc(16, 8'd1, 4'b0101, 2'b11, 2, 1, 3);
    rd0 = rd_n; fd0 = fed_n; d0 = done_n; rl0 = rel_n; rs0 = res_cnt;
    stall_en = 1'b1;
    push(16);
    wait_rel(rl0 + 1);
    stall_en = 1'b0;
    repeat (3) @(negedge clk);
    for (int k = 0; k < 8; k++)
      chk(rd_log[(rd0+k) % 64] == 32'(128 + 8*k), "R2 descriptor read address", 64'(rd_log[(rd0+k) % 64]), 64'(128 + 8*k));
    chk(mask_seen == 4'b0101, "R3 unit mask", 64'(mask_seen), 64'h5);
    chk(fed_n - fd0 == 6, "R5 operand word count", 64'(fed_n - fd0), 6);
    for (int j = 0; j < 6; j++) begin
      int src = (j < 2) ? 64 + j : (j < 3) ? 96 : 128 + (j - 3);
      logic [1:0] s = (j < 2) ? 2'd0 : (j < 3) ? 2'd1 : 2'd2;
      chk(fed_data[(fd0+j) % 256] == pat(src), "R5 operand data order", fed_data[(fd0+j) % 256], pat(src));
      chk(fed_sel[(fd0+j) % 256] == s, "R5 operand kind", 64'(fed_sel[(fd0+j) % 256]), 64'(s));
    end
    for (int j = 0; j < 3; j++)
      chk(mem[192+j] == {32'hCAFE0000, rs0 + 32'(j)}, "R6 result word", mem[192+j], {32'hCAFE0000, rs0 + 32'(j)});
    chk(mem[195] == 64'h5555, "R6 no extra result", mem[195], 64'h5555);
    chk(mem[16] == {8'd1, 4'b0101, 50'd0, 2'b11}, "R7 header writeback", mem[16], {8'd1, 4'b0101, 50'd0, 2'b11});
    chk(mem[24] == {1'b1, 55'd0, 8'd1}, "R7 status word", mem[24], {1'b1, 55'd0, 8'd1});
    chk(done_n - d0 == 1, "R7 done interrupt", 64'(done_n - d0), 1);
    chk(rel_n - rl0 == 1, "R10 release once", 64'(rel_n - rl0), 1);
  endtask

  task automatic t_hold;
    int rd0, ov0, d0, rl0;
    set_desc(0, 8'd2, 4'b1000, 2'b00, 1, 1, 1);
    rd0 = rd_n; ov0 = overlap_n; d0 = done_n; rl0 = rel_n;
    eu_allow = 1'b0;
    push(0);
    repeat (40) @(negedge clk);
    chk(eu_req == 1'b1, "R4 unit request pending", 64'(eu_req), 1);
    chk(rd_n - rd0 == 8, "R4 no operand read before grant", 64'(rd_n - rd0), 8);
    chk(!mem_req, "R4 memory idle while waiting", 64'(mem_req), 0);
    eu_allow = 1'b1;
    wait_rel(rl0 + 1);
    repeat (3) @(negedge clk);
    chk(overlap_n == ov0, "R4 no request overlap", 64'(overlap_n - ov0), 0);
    chk(done_n == d0, "R7 notify off no irq", 64'(done_n - d0), 0);
    chk(mem[8] == 64'h0, "R7 notify off no status", mem[8], 0);
  endtask

  task automatic t_modes;
    int d0, rl0;
    set_desc(0, 8'd3, 4'b0001, 2'b01, 0, 0, 1);
    d0 = done_n; rl0 = rel_n;
    push(0); wait_rel(rl0 + 1); repeat (3) @(negedge clk);
    chk(done_n - d0 == 1, "R7 irq only", 64'(done_n - d0), 1);
    chk(mem[8] == 64'h0, "R7 irq only no status", mem[8], 0);
    set_desc(0, 8'd4, 4'b0001, 2'b10, 0, 0, 1);
    d0 = done_n; rl0 = rel_n;
    push(0); wait_rel(rl0 + 1); repeat (3) @(negedge clk);
    chk(done_n == d0, "R7 writeback only no irq", 64'(done_n - d0), 0);
    chk(mem[8] == {1'b1, 55'd0, 8'd4}, "R7 writeback only status", mem[8], {1'b1, 55'd0, 8'd4});
  endtask

  task automatic t_zero_len;
    int fd0, rl0, w0;
    set_desc(0, 8'd1, 4'b0010, 2'b00, 0, 2, 0);
    fd0 = fed_n; rl0 = rel_n; w0 = wr_n;
    push(0); wait_rel(rl0 + 1); repeat (3) @(negedge clk);
    chk(fed_n - fd0 == 2, "R5 zero length skipped", 64'(fed_n - fd0), 2);
    chk(fed_sel[fd0 % 256] == 2'd1 && fed_sel[(fd0+1) % 256] == 2'd1, "R5 only context fed",
        64'(fed_sel[fd0 % 256]), 1);
    chk(wr_n == w0, "R6 zero data length no writes", 64'(wr_n - w0), 0);
  endtask

  task automatic t_bad_op(input logic [7:0] op);
    int fd0, rd0, w0, d0, e0, rl0;
    set_desc(0, op, 4'b0011, 2'b11, 2, 2, 2);
    fd0 = fed_n; rd0 = rd_n; w0 = wr_n; d0 = done_n; e0 = err_n; rl0 = rel_n;
    push(0); wait_rel(rl0 + 1); repeat (3) @(negedge clk);
    chk(err_n - e0 == 1, "R8 error interrupt", 64'(err_n - e0), 1);
    chk(done_n == d0, "R8 no done interrupt", 64'(done_n - d0), 0);
    chk(rd_n - rd0 == 8 && fed_n == fd0, "R8 no operand reads", 64'(rd_n - rd0), 8);
    chk(wr_n == w0 && mem[8] == 64'h0, "R8 no memory writes", 64'(wr_n - w0), 0);
    chk(rel_n - rl0 == 1, "R10 release on abort", 64'(rel_n - rl0), 1);
    set_desc(0, 8'd2, 4'b0011, 2'b01, 0, 0, 0);
    d0 = done_n; rl0 = rel_n;
    push(0); wait_rel(rl0 + 1); repeat (3) @(negedge clk);
    chk(done_n - d0 == 1, "R8 next job after abort", 64'(done_n - d0), 1);
  endtask

  task automatic t_overflow;
    int d0, rl0;
    set_desc(0, 8'd1, 4'b0001, 2'b01, 0, 0, 0);
    d0 = done_n; rl0 = rel_n;
    @(negedge clk);
    for (int k = 0; k < 6; k++) begin
      host_wr_en = 1'b1; host_wr_ptr = 32'd0;
      @(negedge clk);
    end
    host_wr_en = 1'b0;
    chk(fifo_ovf == 1'b1, "R9 overflow flagged", 64'(fifo_ovf), 1);
    wait_rel(rl0 + 5);
    repeat (40) @(negedge clk);
    chk(done_n - d0 == 5, "R9 dropped write ran no job", 64'(done_n - d0), 5);
    chk(rel_n - rl0 == 5, "R10 one release per job", 64'(rel_n - rl0), 5);
    chk(fifo_ovf == 1'b1, "R9 overflow sticky", 64'(fifo_ovf), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    t_idle_quiet();
    t_basic();
    t_hold();
    t_modes();
    t_zero_len();
    t_bad_op(8'd9);
    t_bad_op(8'd0);
    t_overflow();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule